// File: doc/BRIEF.md
# Complete-Packet Transmit Gate

This block sits beside a single-clock packet FIFO that feeds a transmit MAC. It watches the handshake on both sides of that FIFO and keeps a running count of the whole packets held inside. From that count, and from the MAC's buffer-full flag, it derives one enable. The enable releases data toward the MAC only when at least one finished packet is waiting. As a result, the MAC is never handed a frame whose tail has not yet arrived, and it cannot underrun in the middle of a frame.

Once a frame has begun to flow, the enable stays asserted until that frame's final word has been handed over. A full flag that rises in the middle of a frame therefore cannot cut the frame short. The full flag is honoured only at a frame boundary. The FIFO's read-ready is the enable itself. The valid and start-of-frame strobes presented to the MAC are the FIFO's own strobes qualified by the enable.

Top module: `pkt_tx_gate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `gate_en` and `fifo_rd_ready` are 0 and the held-packet count is zero. A reset during a frame closes the gate, and the gate then stays closed until a new complete packet is written.
- R2: A write-side transfer with `wr_valid`, `wr_ready` and `wr_last` all high raises the held-packet count by one. A write without `wr_last`, or without `wr_ready`, leaves the count unchanged.
- R3: A read-side transfer of a last word, meaning `rd_valid`, `gate_en` and `rd_last` all high, lowers the count by one.
- R4: When a counted write and a counted read occur in the same cycle, the count is unchanged.
- R5: With the gate closed, a nonzero count and `mac_full` low on a clock edge open the gate (`gate_en` = 1) from the next cycle. With a zero count, the gate stays closed.
- R6: With the gate closed, `mac_full` high on an edge keeps the gate closed, whatever the count.
- R7: Once open, the gate stays open until a last word transfers. Neither `mac_full` nor a low `rd_valid` closes it.
- R8: The gate closes in the cycle after a last word transfers. If the count is still nonzero and `mac_full` is low, it reopens one cycle later.
- R9: `fifo_rd_ready` equals `gate_en`. `mac_valid` is `rd_valid` AND `gate_en`. `mac_sof` is `rd_sof` AND `gate_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the FIFO and the MAC side |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | FIFO write-side valid |
| wr_ready | input | 1 | FIFO write-side ready |
| wr_last | input | 1 | Write word ends a packet |
| rd_valid | input | 1 | FIFO read-side valid |
| rd_last | input | 1 | Read word ends a packet |
| rd_sof | input | 1 | Read word starts a packet |
| mac_full | input | 1 | MAC transmit buffer is full |
| gate_en | output | 1 | Registered release enable |
| fifo_rd_ready | output | 1 | Read-ready back to the FIFO |
| mac_valid | output | 1 | Qualified valid toward the MAC |
| mac_sof | output | 1 | Qualified start-of-frame toward the MAC |

## Verification
The properties assume that the FIFO never reports a packet end on its read side that was not first written: every `rd_last` seen while the gate is open belongs to a packet that was counted on the write side. They also assume that the FIFO never holds more packets than `MAX_PKTS`. The stimulus keeps to both assumptions. It drives a read-side last word only while a counted packet is outstanding, and it never queues more than two packets. The one read-side valid driven with a zero count is offered while the gate is closed, so that it only checks the masking.

// File: rtl/pkt_tx_gate_pkg.sv
package pkt_tx_gate_pkg;

  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_SEND = 1'b1
  } gate_state_t;

endpackage

// File: rtl/pkt_tx_gate_counter.sv
module pkt_tx_gate_counter #(
  parameter int MAX_PKTS = 1024,
  localparam int CNT_W = $clog2(MAX_PKTS + 1)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/pkt_tx_gate_fsm.sv
module pkt_tx_gate_fsm
  import pkt_tx_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic have_pkt,
  input  logic mac_full,
  input  logic last_xfer,
  output logic enable
);

  gate_state_t state, state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      GATE_IDLE: if (have_pkt && !mac_full) state_nxt = GATE_SEND;
      GATE_SEND: if (last_xfer)             state_nxt = GATE_IDLE;
      default:                              state_nxt = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= GATE_IDLE;
    else     state <= state_nxt;
  end

  assign enable = (state == GATE_SEND);

endmodule

// File: rtl/pkt_tx_gate.sv
module pkt_tx_gate #(
  parameter int MAX_PKTS = 1024
)(
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  input  logic wr_ready,
  input  logic wr_last,
  input  logic rd_valid,
  input  logic rd_last,
  input  logic rd_sof,
  input  logic mac_full,
  output logic gate_en,
  output logic fifo_rd_ready,
  output logic mac_valid,
  output logic mac_sof
);

  localparam int CNT_W = $clog2(MAX_PKTS + 1);

  logic             push_last;
  logic             pop_last;
  logic [CNT_W-1:0] pkt_cnt;

  assign push_last = wr_valid && wr_ready && wr_last;
  assign pop_last  = rd_valid && gate_en && rd_last;

  pkt_tx_gate_counter #(.MAX_PKTS(MAX_PKTS)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (push_last),
    .dec   (pop_last),
    .count (pkt_cnt)
  );

  pkt_tx_gate_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .have_pkt  (pkt_cnt != '0),
    .mac_full  (mac_full),
    .last_xfer (pop_last),
    .enable    (gate_en)
  );

  assign fifo_rd_ready = gate_en;
  assign mac_valid     = rd_valid && gate_en;
  assign mac_sof       = rd_sof && gate_en;

endmodule

// File: rtl/pkt_tx_gate_chk.sv
module pkt_tx_gate_chk #(
  parameter int MAX_PKTS = 1024,
  localparam int CNT_W = $clog2(MAX_PKTS + 1)
)(
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_last,
  input logic             rd_valid,
  input logic             rd_last,
  input logic             mac_full,
  input logic             gate_en,
  input logic             fifo_rd_ready,
  input logic             mac_valid,
  input logic [CNT_W-1:0] cnt
);

  logic wr_end, rd_end;
  assign wr_end = wr_valid && wr_ready && wr_last;
  assign rd_end = rd_valid && fifo_rd_ready && rd_last;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!gate_en && cnt == '0));

  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_end && !rd_end) |=> cnt == $past(cnt) + CNT_W'(1));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_end && rd_end) |=> cnt == $past(cnt) - CNT_W'(1));

  assert_count_same_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_end && rd_end) |=> cnt == $past(cnt));

  assert_open_needs_pkt_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_en) |-> $past(cnt != '0));

  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (!gate_en && mac_full) |=> !gate_en);

  assert_hold_frame_R7: assert property (@(posedge clk) disable iff (rst)
    (gate_en && !rd_end) |=> gate_en);

  assert_close_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    rd_end |=> !gate_en);

  assert_mac_valid_qual_R9: assert property (@(posedge clk) disable iff (rst)
    mac_valid |-> (fifo_rd_ready && rd_valid));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_PKTS));

endmodule

bind pkt_tx_gate pkt_tx_gate_chk #(.MAX_PKTS(MAX_PKTS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_last       (wr_last),
  .rd_valid      (rd_valid),
  .rd_last       (rd_last),
  .mac_full      (mac_full),
  .gate_en       (gate_en),
  .fifo_rd_ready (fifo_rd_ready),
  .mac_valid     (mac_valid),
  .cnt           (pkt_cnt)
);

// File: tb/pkt_tx_gate_tb.sv
module pkt_tx_gate_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 0, wr_ready = 0, wr_last = 0;
  logic rd_valid = 0, rd_last = 0, rd_sof = 0, mac_full = 0;
  logic gate_en, fifo_rd_ready, mac_valid, mac_sof;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pkt_tx_gate #(.MAX_PKTS(1024)) u_dut (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_last(wr_last),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_sof(rd_sof),
    .mac_full(mac_full),
    .gate_en(gate_en), .fifo_rd_ready(fifo_rd_ready),
    .mac_valid(mac_valid), .mac_sof(mac_sof)
  );

  // {wr_valid, wr_ready, wr_last, rd_valid, rd_last, rd_sof, mac_full} _
  // {exp gate_en, exp mac_valid, exp mac_sof, exp fifo_rd_ready}
  localparam int NV = 24;
  localparam logic [10:0] VEC [0:NV-1] = '{
    11'b0000000_0000,  // 0 idle after reset (R1)
    11'b1110000_0000,  // 1 push packet end (R2)
    11'b0000001_0000,  // 2 full blocks start (R6)
    11'b0000001_0000,  // 3 still blocked (R6)
    11'b0000000_0000,  // 4 full drops, opens after edge (R5)
    11'b0001011_1111,  // 5 open, sof word, full ignored (R7 R9)
    11'b0000000_1001,  // 6 no valid, gate holds (R7 R9)
    11'b0001100_1101,  // 7 last word moves (R3 R8)
    11'b0000000_0000,  // 8 closed (R8)
    11'b0001000_0000,  // 9 valid masked while closed, count zero (R9 R5)
    11'b1110000_0000,  // 10 push (R2)
    11'b1110000_0000,  // 11 push second, gate opens after edge (R2 R5)
    11'b0001110_1111,  // 12 one-word frame (R3 R9)
    11'b0000000_0000,  // 13 closed, reopens after edge (R8)
    11'b1111110_1111,  // 14 push and pop together (R4)
    11'b0000000_0000,  // 15 closed, reopens since count held (R4 R8)
    11'b0001110_1111,  // 16 final frame (R3)
    11'b0000000_0000,  // 17 count zero (R3)
    11'b0000000_0000,  // 18 stays closed (R5)
    11'b1010000_0000,  // 19 end without ready (R2)
    11'b0000000_0000,  // 20
    11'b0000000_0000,  // 21 not counted (R2)
    11'b1100000_0000,  // 22 write without last (R2)
    11'b0000000_0000   // 23
  };

  task automatic check(input string tag, input logic act, input logic exp, input int idx);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s step %0d: actual=%0b expected=%0b", tag, idx, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] v);
    {wr_valid, wr_ready, wr_last, rd_valid, rd_last, rd_sof, mac_full} = v;
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // R1: outputs during reset, even with a valid offered
    drive(7'b0001110);
    repeat (3) @(negedge clk);
    #1;
    check("R1 gate_en in reset", gate_en, 1'b0, -1);
    check("R1 rd_ready in reset", fifo_rd_ready, 1'b0, -1);
    check("R1 mac_valid in reset", mac_valid, 1'b0, -1);
    @(negedge clk);
    drive(7'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10:4]);
      #1;
      check("R5 R6 R7 R8 gate_en", gate_en, VEC[i][3], i);
      check("R9 mac_valid", mac_valid, VEC[i][2], i);
      check("R9 mac_sof", mac_sof, VEC[i][1], i);
      check("R9 fifo_rd_ready", fifo_rd_ready, VEC[i][0], i);
      @(negedge clk);
    end

    // R1: reset during an open frame clears the count and closes the gate
    drive(7'b1110000);
    @(negedge clk);
    drive(7'b0);
    @(negedge clk);
    #1;
    check("R5 gate opened before reset", gate_en, 1'b1, 100);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 gate closed after reset", gate_en, 1'b0, 101);
    repeat (3) @(negedge clk);
    #1;
    check("R1 count cleared, gate stays closed", gate_en, 1'b0, 102);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule